// File: doc/BRIEF.md
# Two-Channel Serial Port with Combined Status Word

This peripheral gives a processor two independent asynchronous serial channels behind one small register port. Each channel has a data register. A write to it places a byte in a one-entry transmit holding register. The byte then moves to a transmit shifter as soon as that shifter is idle. On the receive side each channel has a single-byte buffer. A read of the data register returns the buffered byte and consumes it. Baud timing comes from a fixed clocks-per-bit parameter. Parity is chosen by parameter (enable, odd or even).

Both channels report through one 32-bit status word. Channel A owns bits 7:0 and channel B uses the same layout in bits 23:16. Software clears a channel's error flags by writing 1 to the command bit at position 7 of that channel's byte in the status word. The data path has no back-pressure at the port. Software must poll the holding-empty flag before it writes, because a write that arrives while the holding register is full is discarded. A character that completes while the previous one is still unread overwrites it and raises overrun. Each channel has a one-cycle transfer interrupt, and one shared error interrupt serves both channels.

Top module: `twin_uart`

## Requirements
- R1: After reset the status word reads 0x00060006 (both channels idle on transmit, nothing received, no errors), both serial outputs are high and all interrupts are low.
- R2: A data write into an empty holding register clears holding-empty (lane bit 2) for exactly one cycle; in the next cycle holding-empty is set again and shifter-empty (lane bit 1) is clear.
- R3: A transmitted frame is one low start bit, eight data bits LSB first, an even parity bit (parity enabled, odd disabled by default) and one high stop bit, each lasting CLKS_PER_BIT clocks; the line idles high.
- R4: A received character appears in bits 7:0 of the channel's data register (word address 0 for A, 1 for B) and sets data-ready (lane bit 0).
- R5: Reading a channel's data register clears that channel's data-ready flag.
- R6: A character that completes while data-ready is still set sets overrun (lane bit 6) and replaces the held byte.
- R7: A stop bit sampled low sets framing error (lane bit 4); a parity bit that does not match sets parity error (lane bit 5); the byte is still delivered.
- R8: Writing 1 to status bit 7 clears channel A's three error flags, and writing 1 to bit 23 clears channel B's; a new error in the same cycle wins over the clear; the command bits always read 0.
- R9: Channel B's flags sit at status bits 23:16 in the same layout as A's, and activity on one channel never changes the other channel's flags.
- R10: A data write while the holding register is full is ignored: the byte is never sent.
- R11: err_irq pulses for one cycle when any error flag of either channel goes from 0 to 1.
- R12: chan_irq[n] pulses for one cycle when channel n completes a received character and when its holding register moves to the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (consumes data on data addresses) |
| bus_addr | input | 2 | Word address: 0 data A, 1 data B, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rx_line | input | 2 | Serial inputs, index 0 is channel A |
| tx_line | output | 2 | Serial outputs, index 0 is channel A |
| chan_irq | output | 2 | Per-channel transfer interrupt pulse |
| err_irq | output | 1 | Shared error interrupt pulse |

## Verification
A single write, then a write into a busy shifter followed by a third write, separates the holding-to-shifter move from the discard of a write on a full holding register. Clean frames, back-to-back unread frames, a frame with a low stop bit and a frame with a wrong parity bit each set a different flag, so the exact status word shows whether each flag lands in the right bit of the right lane. Clearing one channel while both hold errors shows whether the clear command is confined to its own lane. A loopback from A's output to B's input checks the transmit frame format against the receiver, while a line decoder in the bench checks every transmitted bit on its own.

// File: rtl/twin_uart_pkg.sv
package twin_uart_pkg;
  localparam int DATA_W      = 8;
  localparam int LANE_STRIDE = 16;
  localparam int LANE_W      = 8;
  localparam int CLR_BIT     = 7;

  localparam logic [1:0] ADDR_DATA_A = 2'd0;
  localparam logic [1:0] ADDR_DATA_B = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  typedef struct packed {
    logic ovr;
    logic par;
    logic frm;
  } err_flags_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  // lane layout: 0 ready, 1 shifter empty, 2 holding empty, 4 frame, 5 parity, 6 overrun
  function automatic logic [LANE_W-1:0] lane_byte(logic dr, logic tse, logic the, err_flags_t e);
    return {1'b0, e.ovr, e.par, e.frm, 1'b0, the, tse, dr};
  endfunction
endpackage

// File: rtl/twin_uart_rx.sv
module twin_uart_rx
  import twin_uart_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int PARITY_EN    = 1,
  parameter int PARITY_ODD   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              frame_bad,
  output logic              parity_bad
);
  localparam int NB = DATA_W + PARITY_EN;
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int IW = $clog2(NB + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(CLKS_PER_BIT / 2 - 1);

  logic          rx_meta, rx_s, rx_q;
  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [NB-1:0] sh;
  logic          par_fail_w;

  generate
    if (PARITY_EN != 0) begin : g_par
      assign par_fail_w = (^sh[DATA_W-1:0] ^ sh[NB-1]) != (PARITY_ODD != 0);
    end else begin : g_nopar
      assign par_fail_w = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta    <= 1'b1;
      rx_s       <= 1'b1;
      rx_q       <= 1'b1;
      st         <= RX_IDLE;
      cnt        <= '0;
      idx        <= '0;
      sh         <= '0;
      done       <= 1'b0;
      data       <= '0;
      frame_bad  <= 1'b0;
      parity_bad <= 1'b0;
    end else begin
      rx_meta <= rx;
      rx_s    <= rx_meta;
      rx_q    <= rx_s;
      done    <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          // rearm only on a high-to-low edge, so a held-low line is not a new frame
          if (!rx_s && rx_q) begin
            st  <= RX_START;
            cnt <= HALF_CNT;
          end
        end
        RX_START: begin
          if (cnt == '0) begin
            if (!rx_s) begin
              st  <= RX_BITS;
              cnt <= FULL_CNT;
              idx <= '0;
            end else begin
              st <= RX_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt == '0) begin
            sh  <= {rx_s, sh[NB-1:1]};
            cnt <= FULL_CNT;
            if (idx == IW'(NB - 1)) st <= RX_STOP;
            else                    idx <= idx + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == '0) begin
            done       <= 1'b1;
            data       <= sh[DATA_W-1:0];
            frame_bad  <= !rx_s;
            parity_bad <= par_fail_w;
            st         <= RX_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twin_uart_tx.sv
module twin_uart_tx
  import twin_uart_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int PARITY_EN    = 1,
  parameter int PARITY_ODD   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              tx,
  output logic              busy
);
  localparam int FW = DATA_W + PARITY_EN + 2;
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam int LW = $clog2(FW);
  localparam logic [CW-1:0] FULL_CNT = CW'(CLKS_PER_BIT - 1);

  logic [FW-1:0] fr, frame_w;
  logic [CW-1:0] cnt;
  logic [LW-1:0] left;

  generate
    if (PARITY_EN != 0) begin : g_par
      assign frame_w = {1'b1, (^din) ^ (PARITY_ODD != 0), din, 1'b0};
    end else begin : g_nopar
      assign frame_w = {1'b1, din, 1'b0};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr   <= '1;
      busy <= 1'b0;
      cnt  <= '0;
      left <= '0;
    end else if (load) begin
      fr   <= frame_w;
      busy <= 1'b1;
      cnt  <= FULL_CNT;
      left <= LW'(FW - 1);
    end else if (busy) begin
      if (cnt == '0) begin
        fr  <= {1'b1, fr[FW-1:1]};
        cnt <= FULL_CNT;
        if (left == '0) busy <= 1'b0;
        else            left <= left - 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign tx = busy ? fr[0] : 1'b1;
endmodule

// File: rtl/twin_uart_chan.sv
module twin_uart_chan
  import twin_uart_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int PARITY_EN    = 1,
  parameter int PARITY_ODD   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_strobe,
  input  logic              clr_strobe,
  input  logic              rx,
  output logic              tx,
  output logic [LANE_W-1:0] lane_status,
  output logic [DATA_W-1:0] rd_byte,
  output logic              irq,
  output logic              err_rise
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_byte;
  logic              tx_busy, load_tx;
  logic              rx_done, fb, pb;
  logic [DATA_W-1:0] rx_byte;
  logic              dr;
  err_flags_t        errs, raise, errs_nxt;

  assign load_tx = hold_full && !tx_busy;

  twin_uart_tx #(
    .CLKS_PER_BIT(CLKS_PER_BIT), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .load(load_tx), .din(hold_byte), .tx(tx), .busy(tx_busy)
  );

  twin_uart_rx #(
    .CLKS_PER_BIT(CLKS_PER_BIT), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .rx(rx), .done(rx_done), .data(rx_byte),
    .frame_bad(fb), .parity_bad(pb)
  );

  always_comb begin
    raise.ovr = rx_done && dr;
    raise.par = rx_done && pb;
    raise.frm = rx_done && fb;
    // a fresh error outranks a clear in the same cycle
    errs_nxt  = err_flags_t'((clr_strobe ? 3'b000 : errs) | raise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_byte <= '0;
      dr        <= 1'b0;
      rd_byte   <= '0;
      errs      <= '0;
      err_rise  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (load_tx) begin
        hold_full <= 1'b0;
      end else if (wr_strobe && !hold_full) begin
        hold_full <= 1'b1;
        hold_byte <= wr_byte;
      end
      if (rx_done) begin
        dr      <= 1'b1;
        rd_byte <= rx_byte;
      end else if (rd_strobe) begin
        dr <= 1'b0;
      end
      errs     <= errs_nxt;
      err_rise <= |(raise & ~errs);
      irq      <= rx_done || load_tx;
    end
  end

  assign lane_status = lane_byte(dr, !tx_busy, !hold_full, errs);
endmodule

// File: rtl/twin_uart.sv
module twin_uart
  import twin_uart_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int PARITY_EN    = 1,
  parameter int PARITY_ODD   = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  rx_line,
  output logic [1:0]  tx_line,
  output logic [1:0]  chan_irq,
  output logic        err_irq
);
  localparam int NCH = 2;

  logic [31:0]       stat_word;
  logic [LANE_W-1:0] lane [NCH];
  logic [DATA_W-1:0] rbyte [NCH];
  logic [NCH-1:0]    err_r;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic wr_s, rd_s, clr_s;
      assign wr_s  = bus_wr && (bus_addr == (ADDR_DATA_A + 2'(ch)));
      assign rd_s  = bus_rd && (bus_addr == (ADDR_DATA_A + 2'(ch)));
      assign clr_s = bus_wr && (bus_addr == ADDR_STATUS) && bus_wdata[ch*LANE_STRIDE + CLR_BIT];

      twin_uart_chan #(
        .CLKS_PER_BIT(CLKS_PER_BIT), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)
      ) u_chan (
        .clk(clk), .rst_n(rst_n),
        .wr_strobe(wr_s), .wr_byte(bus_wdata[DATA_W-1:0]),
        .rd_strobe(rd_s), .clr_strobe(clr_s),
        .rx(rx_line[ch]), .tx(tx_line[ch]),
        .lane_status(lane[ch]), .rd_byte(rbyte[ch]),
        .irq(chan_irq[ch]), .err_rise(err_r[ch])
      );

      assign stat_word[ch*LANE_STRIDE +: LANE_W]          = lane[ch];
      assign stat_word[ch*LANE_STRIDE + LANE_W +: LANE_W] = '0;
    end
  endgenerate

  assign err_irq = |err_r;

  always_comb begin
    unique case (bus_addr)
      ADDR_DATA_A: bus_rdata = {24'd0, rbyte[0]};
      ADDR_DATA_B: bus_rdata = {24'd0, rbyte[1]};
      ADDR_STATUS: bus_rdata = stat_word;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/twin_uart_chk.sv
module twin_uart_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] stat_word,
  input logic [1:0]  tx_line,
  input logic [1:0]  chan_irq,
  input logic        err_irq
);
  // R1 / R3: an idle shifter leaves the line high
  p_idle_high_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[1] |-> tx_line[0]);
  p_idle_high_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[17] |-> tx_line[1]);

  // R2: a full holding register with an idle shifter moves on the next edge
  p_hold_move_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_word[2] && stat_word[1]) |=> (stat_word[2] && !stat_word[1]));
  p_hold_move_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_word[18] && stat_word[17]) |=> (stat_word[18] && !stat_word[17]));

  // R12: a rising data-ready comes with the channel pulse
  p_rx_irq_a_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[0]) |-> chan_irq[0]);
  p_rx_irq_b_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[16]) |-> chan_irq[1]);

  // R11: an error pulse only appears with an error flag held
  p_err_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ((|stat_word[6:4]) || (|stat_word[22:20])));

  // R8: command bits read back as zero
  always @(posedge clk) begin
    if (rst_n) begin
      p_cmd_zero_r8: assert (!stat_word[7] && !stat_word[23]);
    end
  end
endmodule

bind twin_uart twin_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_word(stat_word),
  .tx_line(tx_line), .chan_irq(chan_irq), .err_irq(err_irq)
);

// File: tb/twin_uart_tb.sv
module twin_uart_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;
  localparam int FRAME_CLKS = 11 * BIT_CLKS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  rx_drv = 2'b11;
  logic        loop_en = 1'b0;
  logic [1:0]  rx_line, tx_line, chan_irq;
  logic        err_irq;

  int checks = 0, errors = 0;
  int irq_a = 0, irq_b = 0, err_cnt = 0;
  logic [7:0] got_a[$], got_b[$];

  assign rx_line = {loop_en ? tx_line[0] : rx_drv[1], rx_drv[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_uart #(.CLKS_PER_BIT(BIT_CLKS), .PARITY_EN(1), .PARITY_ODD(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_line(rx_line), .tx_line(tx_line),
    .chan_irq(chan_irq), .err_irq(err_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // pulse counters sampled away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (chan_irq[0]) irq_a++;
      if (chan_irq[1]) irq_b++;
      if (err_irq) err_cnt++;
    end
  end

  // behavioural line decoder: finds a start bit and samples each bit centre
  task automatic decode_line(input int ch);
    logic [7:0] b;
    logic       p;
    forever begin
      @(negedge clk);
      if (rst_n && tx_line[ch] == 1'b0) begin
        repeat (BIT_CLKS/2) @(negedge clk);
        check("R3 start bit", {31'd0, tx_line[ch]}, 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT_CLKS) @(negedge clk);
          b[i] = tx_line[ch];
        end
        repeat (BIT_CLKS) @(negedge clk);
        p = tx_line[ch];
        check("R3 even parity", {31'd0, p}, {31'd0, ^b});
        repeat (BIT_CLKS) @(negedge clk);
        check("R3 stop bit", {31'd0, tx_line[ch]}, 32'd1);
        if (ch == 0) got_a.push_back(b);
        else         got_b.push_back(b);
      end
    end
  endtask

  task automatic peek(output logic [31:0] v);
    bus_addr = 2'd2;
    #1;
    v = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic send_frame(input int ch, input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic [10:0] bits;
    bits = {!bad_stop, (^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rx_drv[ch] = bits[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rx_drv[ch] = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    fork
      decode_line(0);
      decode_line(1);
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(v);
    check("R1 reset status", v, 32'h0006_0006);
    check("R1 reset lines", {28'd0, tx_line, chan_irq}, {28'd0, 2'b11, 2'b00});
    check("R1 reset err_irq", {31'd0, err_irq}, 32'd0);

    // R2: holding register fills, then hands over to the shifter
    bus_write(2'd0, 32'h0000_00A5);
    peek(v);
    check("R2 holding full", v, 32'h0006_0002);
    @(negedge clk);
    peek(v);
    check("R2 moved to shifter", v, 32'h0006_0004);
    repeat (FRAME_CLKS + 10) @(negedge clk);

    // R10: third write lands on a full holding register
    bus_write(2'd0, 32'h0000_0011);
    repeat (2) @(negedge clk);
    bus_write(2'd0, 32'h0000_0022);
    bus_write(2'd0, 32'h0000_0033);
    peek(v);
    check("R10 both transmit stages busy", v, 32'h0006_0000);
    repeat (2*FRAME_CLKS + 30) @(negedge clk);

    // R4 / R5: clean receive then consume
    send_frame(0, 8'h3C, 1'b0, 1'b0);
    peek(v);
    check("R4 data ready A", v, 32'h0006_0007);
    bus_read(2'd0, v);
    check("R4 data A byte", v, 32'h0000_003C);
    peek(v);
    check("R5 ready cleared", v, 32'h0006_0006);

    // R6 / R7 / R9: overrun, framing error, parity error on B
    send_frame(0, 8'h12, 1'b0, 1'b0);
    send_frame(0, 8'h34, 1'b0, 1'b0);
    send_frame(0, 8'h77, 1'b0, 1'b1);
    repeat (BIT_CLKS) @(negedge clk);
    send_frame(1, 8'h0F, 1'b1, 1'b0);
    peek(v);
    check("R6 R7 R9 error lanes", v, 32'h0027_0057);
    bus_read(2'd0, v);
    check("R6 newest byte kept", v, 32'h0000_0077);
    bus_read(2'd1, v);
    check("R7 byte with parity error kept", v, 32'h0000_000F);
    check("R11 error pulses", err_cnt, 32'd3);

    // R8: clear A only, then B
    bus_write(2'd2, 32'h0000_0080);
    peek(v);
    check("R8 clear A leaves B", v, 32'h0026_0006);
    bus_write(2'd2, 32'h0080_0000);
    peek(v);
    check("R8 clear B", v, 32'h0006_0006);

    // loopback: A transmitter feeds B receiver
    loop_en = 1'b1;
    bus_write(2'd0, 32'h0000_005C);
    repeat (FRAME_CLKS + 20) @(negedge clk);
    peek(v);
    check("R9 loopback ready B", v, 32'h0007_0006);
    bus_read(2'd1, v);
    check("R3 loopback byte", v, 32'h0000_005C);
    loop_en = 1'b0;
    bus_write(2'd1, 32'h0000_00E7);
    repeat (FRAME_CLKS + 20) @(negedge clk);

    check("R10 frames sent on A", got_a.size(), 32'd4);
    if (got_a.size() == 4) begin
      check("R3 byte A0", {24'd0, got_a[0]}, 32'hA5);
      check("R3 byte A1", {24'd0, got_a[1]}, 32'h11);
      check("R10 byte A2", {24'd0, got_a[2]}, 32'h22);
      check("R3 byte A3", {24'd0, got_a[3]}, 32'h5C);
    end
    check("R9 frames sent on B", got_b.size(), 32'd1);
    if (got_b.size() == 1) check("R9 byte B0", {24'd0, got_b[0]}, 32'hE7);
    check("R12 irq count A", irq_a, 32'd8);
    check("R12 irq count B", irq_b, 32'd3);
    check("R11 error pulses total", err_cnt, 32'd3);
    finish_run();
  end
endmodule